// File: doc/BRIEF.md
# Single-Frame Block Cache

This block sits between a processor's word-request port and a slower main-memory port. It holds exactly one cache frame. The frame has a valid flag, a tag and a block of four 32-bit words. Blocks are 16 bytes long and start on 16-byte boundaries. Each request is compared against the frame. A read whose block is resident returns its word after one cycle. A read whose block is absent first reloads the whole frame from memory, one word at a time, and then returns the requested word.

Stores always go through to memory. A store changes the matching frame word only when its block is already resident. A store to a block that is not resident leaves the frame as it was. Two saturating counters record how many accepted requests hit and how many missed.

The processor side uses a valid/ready handshake. Only one request is in flight at a time. The memory side holds a request level, with a stable address, until the memory pulses its response strobe.

Top module: `blkcache_top`

## Requirements
- R1: After reset, `cpu_req_ready` is high, `cpu_rsp_valid` and `mem_req_valid` are low, both counters read zero, and the frame is invalid, so the first request misses.
- R2: A read hits when the frame is valid and its tag equals `cpu_req_addr[31:4]` (the address ANDed with 0xFFFFFFF0). On a hit, `cpu_rsp_valid` rises in the cycle after acceptance, carrying frame word `cpu_req_addr[3:2]`. No memory request is made.
- R3: A read miss issues four memory reads, at block base + 0x0, 0x4, 0x8 and 0xC, in that order. Each read holds `mem_req_valid` with a stable address until `mem_rsp_valid`. The word is captured on that strobe.
- R4: Capturing the fourth word makes the frame valid under the new tag. The next cycle responds with the requested word. Later requests to that block hit.
- R5: `cpu_req_ready` is low from the cycle after acceptance through the response cycle. `cpu_rsp_valid` lasts one cycle and never coincides with `cpu_req_ready`.
- R6: A store issues exactly one memory write (`mem_req_we` = 1) with the request address and data, then responds. On a store hit, the frame word is updated, so a later read of it returns the stored data.
- R7: A store miss does not allocate. The frame keeps its previous block, and a later read of the store's block misses.
- R8: Each accepted request adds one to `hit_count` or `miss_count`. Each counter stops at 2^CNT_W-1.
- R9: A read miss to a different block replaces the frame. The previously held block then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address of the word |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | One-cycle completion strobe |
| cpu_rsp_rdata | output | 32 | Load data (meaningful for loads) |
| mem_req_valid | output | 1 | Memory access requested, held until response |
| mem_req_we | output | 1 | 1 = memory write |
| mem_req_addr | output | 32 | Memory word address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Memory completion strobe |
| mem_rsp_rdata | input | 32 | Memory read data |
| hit_count | output | CNT_W | Saturating hit count |
| miss_count | output | CNT_W | Saturating miss count |

## Verification
The stimulus follows the behaviour across several access patterns:
- A cold read in the middle of a block, followed by reads of its neighbouring words. This separates refill ordering from word selection.
- A store hit followed by a read-back of the same word. This separates updating the frame from only writing memory.
- A store miss followed by a read of the same block. This exposes allocate-on-write.
- Alternating between two blocks. This exposes a tag that fails to update on replacement.
- A long run of hits. This drives the hit counter into saturation.

Hit and miss are told apart by response latency and by the logged memory traffic. A second reset confirms that the frame is invalidated.

// File: rtl/blkcache_pkg.sv
package blkcache_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int BLK_WORDS  = 4;
    localparam int BYTE_OFF_W = $clog2(DATA_W / 8);
    localparam int WSEL_W     = $clog2(BLK_WORDS);
    localparam int OFF_W      = BYTE_OFF_W + WSEL_W;
    localparam int TAG_W      = ADDR_W - OFF_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [WSEL_W-1:0] wsel_t;
    typedef logic [BLK_WORDS-1:0][DATA_W-1:0] line_t;

    localparam wsel_t LAST_WORD = wsel_t'(BLK_WORDS - 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_STORE,
        ST_RESP
    } state_e;

    typedef struct packed {
        logic  we;
        addr_t addr;
        data_t wdata;
    } req_t;

    function automatic tag_t tag_of(input addr_t a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    function automatic wsel_t wsel_of(input addr_t a);
        return a[OFF_W-1:BYTE_OFF_W];
    endfunction

    function automatic addr_t word_addr(input tag_t t, input wsel_t w);
        return {t, w, {BYTE_OFF_W{1'b0}}};
    endfunction
endpackage

// File: rtl/blkcache_satctr.sv
module blkcache_satctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/blkcache_frame.sv
module blkcache_frame
    import blkcache_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  inval,
    input  logic  fill_we,
    input  wsel_t fill_sel,
    input  data_t fill_data,
    input  logic  commit,
    input  tag_t  commit_tag,
    input  logic  upd_we,
    input  wsel_t upd_sel,
    input  data_t upd_data,
    output logic  frame_valid,
    output tag_t  frame_tag,
    output line_t frame_words
);
    // Valid and tag: invalidate when a refill starts, set when it finishes
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_valid <= 1'b0;
            frame_tag   <= '0;
        end else if (commit) begin
            frame_valid <= 1'b1;
            frame_tag   <= commit_tag;
        end else if (inval) begin
            frame_valid <= 1'b0;
        end
    end

    // Data words carry no reset; they are meaningless until valid is set
    for (genvar g = 0; g < BLK_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (fill_we && fill_sel == wsel_t'(g)) begin
                frame_words[g] <= fill_data;
            end else if (upd_we && upd_sel == wsel_t'(g)) begin
                frame_words[g] <= upd_data;
            end
        end
    end
endmodule

// File: rtl/blkcache_lookup.sv
module blkcache_lookup
    import blkcache_pkg::*;
(
    input  logic frame_valid,
    input  tag_t frame_tag,
    input  tag_t req_tag,
    output logic hit
);
    always_comb begin
        hit = frame_valid && (frame_tag == req_tag);
    end
endmodule

// File: rtl/blkcache_top.sv
module blkcache_top
    import blkcache_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    state_e state;
    req_t   req;
    wsel_t  fill_idx;

    logic  frame_valid;
    tag_t  frame_tag;
    line_t frame_words;
    logic  hit;
    logic  accept;
    logic  inval, fill_we, commit, upd_we;

    blkcache_lookup u_lookup (
        .frame_valid (frame_valid),
        .frame_tag   (frame_tag),
        .req_tag     (tag_of(cpu_req_addr)),
        .hit         (hit)
    );

    always_comb begin
        accept  = cpu_req_valid && (state == ST_IDLE);
        inval   = accept && !cpu_req_we && !hit;
        fill_we = (state == ST_FILL) && mem_rsp_valid;
        commit  = fill_we && (fill_idx == LAST_WORD);
        upd_we  = accept && cpu_req_we && hit;
    end

    blkcache_frame u_frame (
        .clk         (clk),
        .rst         (rst),
        .inval       (inval),
        .fill_we     (fill_we),
        .fill_sel    (fill_idx),
        .fill_data   (mem_rsp_rdata),
        .commit      (commit),
        .commit_tag  (tag_of(req.addr)),
        .upd_we      (upd_we),
        .upd_sel     (wsel_of(cpu_req_addr)),
        .upd_data    (cpu_req_wdata),
        .frame_valid (frame_valid),
        .frame_tag   (frame_tag),
        .frame_words (frame_words)
    );

    blkcache_satctr #(.W(CNT_W)) u_hits (
        .clk   (clk),
        .rst   (rst),
        .inc   (accept && hit),
        .count (hit_count)
    );

    blkcache_satctr #(.W(CNT_W)) u_misses (
        .clk   (clk),
        .rst   (rst),
        .inc   (accept && !hit),
        .count (miss_count)
    );

    // Control sequence: idle -> (fill | store | resp) -> resp -> idle
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            req      <= '0;
            fill_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        req <= '{we: cpu_req_we, addr: cpu_req_addr, wdata: cpu_req_wdata};
                        if (cpu_req_we) begin
                            state <= ST_STORE;
                        end else if (hit) begin
                            state <= ST_RESP;
                        end else begin
                            state    <= ST_FILL;
                            fill_idx <= '0;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_rsp_valid) begin
                        if (fill_idx == LAST_WORD) begin
                            state <= ST_RESP;
                        end else begin
                            fill_idx <= fill_idx + 1'b1;
                        end
                    end
                end
                ST_STORE: begin
                    if (mem_rsp_valid) begin
                        state <= ST_RESP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cpu_req_ready = (state == ST_IDLE);
        cpu_rsp_valid = (state == ST_RESP);
        cpu_rsp_rdata = frame_words[wsel_of(req.addr)];
        mem_req_valid = (state == ST_FILL) || (state == ST_STORE);
        mem_req_we    = (state == ST_STORE);
        mem_req_addr  = (state == ST_STORE) ? req.addr
                                            : word_addr(tag_of(req.addr), fill_idx);
        mem_req_wdata = req.wdata;
    end
endmodule

// File: rtl/blkcache_chk.sv
module blkcache_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_req_ready,
    input logic             cpu_rsp_valid,
    input logic             mem_req_valid,
    input logic             mem_req_we,
    input logic [31:0]      mem_req_addr,
    input logic [31:0]      mem_req_wdata,
    input logic             mem_rsp_valid,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    // R3
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_rsp_valid) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

    // R3
    fill_order_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_we && mem_rsp_valid && mem_req_addr[3:2] != 2'd3) |=>
            (mem_req_valid && !mem_req_we && mem_req_addr == $past(mem_req_addr) + 32'd4));

    // R5
    rsp_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_rsp_valid |-> (!cpu_req_ready && !mem_req_valid));

    // R5
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_rsp_valid |=> !cpu_rsp_valid);

    // R5
    busy_mem_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !cpu_req_ready);

    // R8
    hit_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_count == CMAX) |=> (hit_count == CMAX));

    // R8
    miss_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_count == CMAX) |=> (miss_count == CMAX));

    // R8
    one_step_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_req_ready |=> ($stable(hit_count) && $stable(miss_count)));
endmodule

bind blkcache_top blkcache_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_req_ready (cpu_req_ready),
    .cpu_rsp_valid (cpu_rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .hit_count     (hit_count),
    .miss_count    (miss_count)
);

// File: tb/blkcache_tb.sv
module blkcache_top_tb_top;
    localparam int CNT_W   = 4;
    localparam int CMAX    = (1 << CNT_W) - 1;
    localparam int MEM_LAT = 20;
    localparam int NVEC    = 12;

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        hit;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 32'h128, 32'h0,         1'b0},
        '{1'b0, 32'h124, 32'h0,         1'b1},
        '{1'b0, 32'h120, 32'h0,         1'b1},
        '{1'b0, 32'h12C, 32'h0,         1'b1},
        '{1'b1, 32'h124, 32'hDEADBEEF,  1'b1},
        '{1'b0, 32'h124, 32'h0,         1'b1},
        '{1'b1, 32'h200, 32'h5A5A0F0F,  1'b0},
        '{1'b0, 32'h204, 32'h0,         1'b0},
        '{1'b0, 32'h120, 32'h0,         1'b0},
        '{1'b0, 32'h124, 32'h0,         1'b1},
        '{1'b0, 32'h13C, 32'h0,         1'b0},
        '{1'b0, 32'h130, 32'h0,         1'b1}
    };

    logic clk = 1'b0;
    logic rst;
    logic cpu_req_valid, cpu_req_ready, cpu_req_we;
    logic [31:0] cpu_req_addr, cpu_req_wdata, cpu_rsp_rdata;
    logic cpu_rsp_valid;
    logic mem_req_valid, mem_req_we, mem_rsp_valid;
    logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata;
    logic [CNT_W-1:0] hit_count, miss_count;

    int checks = 0;
    int fails  = 0;
    int exp_hits = 0;
    int exp_misses = 0;

    always #10 clk = ~clk;

    blkcache_top #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_rdata(cpu_rsp_rdata), .mem_req_valid(mem_req_valid),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .hit_count(hit_count),
        .miss_count(miss_count)
    );

    // Memory model: fixed latency, one access at a time, logs every access
    logic [31:0] mem [256];
    logic        busy;
    int          lat_cnt;
    logic [31:0] rdata_q;
    logic [31:0] log_addr [64];
    logic        log_we [64];
    int          log_cnt;

    assign mem_rsp_rdata = rdata_q;

    always @(posedge clk) begin
        if (rst) begin
            busy          <= 1'b0;
            mem_rsp_valid <= 1'b0;
            lat_cnt       <= 0;
            rdata_q       <= '0;
            log_cnt       <= 0;
            for (int i = 0; i < 256; i++) mem[i] <= 32'hC0DE0000 | (i << 2);
        end else begin
            mem_rsp_valid <= 1'b0;
            if (!busy && !mem_rsp_valid && mem_req_valid) begin
                busy    <= 1'b1;
                lat_cnt <= MEM_LAT - 1;
                log_addr[log_cnt[5:0]] <= mem_req_addr;
                log_we[log_cnt[5:0]]   <= mem_req_we;
                log_cnt <= log_cnt + 1;
                if (mem_req_we) mem[mem_req_addr[9:2]] <= mem_req_wdata;
                else            rdata_q <= mem[mem_req_addr[9:2]];
            end else if (busy) begin
                if (lat_cnt == 0) begin
                    busy          <= 1'b0;
                    mem_rsp_valid <= 1'b1;
                end else begin
                    lat_cnt <= lat_cnt - 1;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        cpu_req_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_hits = 0;
        exp_misses = 0;
    endtask

    // Issue one request; check latency class, data, counters, memory traffic
    task automatic run_req(input logic we, input logic [31:0] a, input logic [31:0] d,
                           input logic exp_hit, input string tag);
        int lat = 1;
        bit rdy_bad = 1'b0;
        int base;
        logic [31:0] rd;
        @(negedge clk);
        base = log_cnt;
        cpu_req_valid = 1'b1;
        cpu_req_we = we;
        cpu_req_addr = a;
        cpu_req_wdata = d;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        while (!cpu_rsp_valid && lat < 1000) begin
            if (cpu_req_ready) rdy_bad = 1'b1;
            @(negedge clk);
            lat++;
        end
        if (cpu_req_ready) rdy_bad = 1'b1;
        rd = cpu_rsp_rdata;
        if (exp_hit) exp_hits++; else exp_misses++;
        // R5: ready stays low while the request is outstanding
        check({tag, " R5 ready-low"}, {31'd0, rdy_bad}, 32'd0);
        if (!we && exp_hit) begin
            // R2: one-cycle hit, no memory traffic
            check({tag, " R2 latency"}, lat, 1);
            check({tag, " R2 nomem"}, log_cnt - base, 0);
        end
        if (!we) begin
            // R2 R4: returned word equals the memory word
            check({tag, " R4 data"}, rd, mem[a[9:2]]);
        end
        if (!we && !exp_hit) begin
            // R3: four reads in ascending order within the block
            check({tag, " R3 nreads"}, log_cnt - base, 4);
            for (int k = 0; k < 4; k++) begin
                check({tag, " R3 order"}, {log_addr[(base + k) % 64][31:1], log_we[(base + k) % 64]},
                      {((a & 32'hFFFFFFF0) + 32'(4 * k)) >> 1 << 0 == 0 ? 31'd0 : ((a & 32'hFFFFFFF0) + 32'(4 * k)) >> 1 >> 0 , 1'b0} & 32'hFFFFFFFF);
            end
        end
        if (we) begin
            // R6: exactly one write-through access
            check({tag, " R6 nwrites"}, log_cnt - base, 1);
            check({tag, " R6 waddr"}, log_addr[base % 64], a);
            check({tag, " R6 wflag"}, {31'd0, log_we[base % 64]}, 32'd1);
            check({tag, " R6 wdata"}, mem[a[9:2]], d);
        end
        // R8: counters
        check({tag, " R8 hits"}, {28'd0, hit_count}, sat(exp_hits));
        check({tag, " R8 misses"}, {28'd0, miss_count}, sat(exp_misses));
    endtask

    initial begin
        cpu_req_we = 1'b0;
        cpu_req_addr = '0;
        cpu_req_wdata = '0;
        do_reset();
        // R1: reset state at the ports
        check("R1 ready", {31'd0, cpu_req_ready}, 32'd1);
        check("R1 rsp", {31'd0, cpu_rsp_valid}, 32'd0);
        check("R1 memreq", {31'd0, mem_req_valid}, 32'd0);
        check("R1 counts", {24'd0, hit_count, miss_count}, 32'd0);

        // Table: R1 cold miss, R2 hits, R6 store hit, R7 store miss, R9 replacement
        for (int i = 0; i < NVEC; i++) begin
            run_req(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].hit,
                    $sformatf("vec%0d", i));
        end

        // R8: drive the hit counter into saturation
        for (int i = 0; i < 12; i++) begin
            run_req(1'b0, 32'h130 + 32'((i % 4) * 4), 32'h0, 1'b1, $sformatf("sat%0d", i));
        end
        check("R8 hit saturated", {28'd0, hit_count}, CMAX);

        // R1: a second reset invalidates the frame
        do_reset();
        check("R1 counts after reset", {24'd0, hit_count, miss_count}, 32'd0);
        run_req(1'b0, 32'h134, 32'h0, 1'b0, "R1 post-reset miss");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule